// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets synchronous logic reach an external asynchronous static RAM of 131072 bytes. A request port with a valid/ready handshake takes a read/write flag, a 17-bit address and a byte of write data. A read returns its byte on a response port that carries a one-cycle valid pulse. On the device side the controller drives the address, the active-low select, write strobe and output enable, and it splits the bidirectional byte lane into an outgoing value, an incoming value and a drive enable for the pad.

The device has no clock, so every phase of a transfer lasts a whole number of system clocks. That number comes from the device's nanosecond minimums, divided by the clock period and rounded up. Two parameters set these counts: the clock period in nanoseconds and a speed grade (0 for the faster part, 1 for the slower part). Writes keep output enable high so that the RAM never drives the lane while the controller does. After each read the controller waits a turnaround gap before it can drive the lane again.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, select, write strobe and output enable are all high, the drive enable is low, ready is high and response valid is low.
- R2: Ready is high only when no transfer is in progress. A request is taken on a clock edge where valid and ready are both high. Select, write strobe and output enable stay high whenever ready is high.
- R3: A read holds select and output enable low and write strobe high for exactly ACC cycles. ACC is the access time (10 ns for grade 0, 12 ns for grade 1) divided by the clock period and rounded up, and is never less than 1.
- R4: The byte returned by a read is the value the RAM presents at the end of the access window. Response valid is high for exactly one cycle per read.
- R5: The read address is on the bus for at least one cycle before select falls, and it does not change while select falls.
- R6: A write holds write strobe low for exactly WP cycles. WP is the strobe minimum (8 ns for grade 0, 10 ns for grade 1) divided by the clock period and rounded up, and is never less than 1. Select stays low and output enable stays high for the whole strobe.
- R7: The drive enable, outgoing data and address are set at least one cycle before write strobe falls. They stay unchanged until at least one cycle after the strobe rises.
- R8: The drive enable is never high while output enable is low. After output enable rises it stays low for more than TA cycles. TA is the release time (5 ns for grade 0, 6 ns for grade 1) divided by the clock period and rounded up, and is never less than 1.
- R9: A read from an address returns the byte most recently written there, including at address 0 and at address 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | DATA_W | Byte read |
| mem_addr | output | ADDR_W | Address to the RAM |
| mem_cs_n | output | 1 | Active-low select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dout | output | DATA_W | Byte driven onto the lane |
| mem_din | input | DATA_W | Byte read from the lane |
| mem_dq_oe | output | 1 | Pad drive enable for the lane |

## Verification
The assertions check on every cycle that the strobe and access windows have the right lengths, that no contention occurs between output enable and the drive enable, that the turnaround gap is kept, that the address is set up before a read and held through a write, and that the response pulse lasts one cycle. They cannot show that the right byte reaches the right location. The bench's RAM model shows this: it gives the wrong value on reads sampled before the access time has passed, and it stores only at the end of the strobe, so read-back checks across random and corner addresses catch a window that is too short or data that is released too early.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_SETUP,
    S_RD_WAIT,
    S_RD_DONE,
    S_TURNAROUND,
    S_WR_SETUP,
    S_WR_STROBE,
    S_WR_RELEASE
  } ctl_state_t;

  // Minimum overlap of select and write strobe
  function automatic int strobe_ns(input int grade);
    return (grade == 0) ? 8 : 10;
  endfunction

  // Address / select to valid read data
  function automatic int access_ns(input int grade);
    return (grade == 0) ? 10 : 12;
  endfunction

  // Worst-case time for RAM outputs to float after disable
  function automatic int release_ns(input int grade);
    return (grade == 0) ? 5 : 6;
  endfunction

  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int ACC_CYC = 2,
  parameter int WP_CYC  = 1,
  parameter int TA_CYC  = 1,
  parameter int CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             timer_zero,
  output logic             accept,
  output logic             sample,
  output logic             tload,
  output logic [CNT_W-1:0] tval,
  output logic             ready,
  output logic             rvalid,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);
  ctl_state_t state;

  assign accept = ready && req_valid;
  assign sample = (state == S_RD_WAIT) && timer_zero;

  always_comb begin
    tload = 1'b0;
    tval  = '0;
    unique case (state)
      S_RD_SETUP: begin tload = 1'b1; tval = CNT_W'(ACC_CYC - 1); end
      S_RD_DONE:  begin tload = 1'b1; tval = CNT_W'(TA_CYC - 1);  end
      S_WR_SETUP: begin tload = 1'b1; tval = CNT_W'(WP_CYC - 1);  end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      ready  <= 1'b1;
      rvalid <= 1'b0;
      cs_n   <= 1'b1;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
      dq_oe  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          ready <= 1'b0;
          if (req_write) begin
            state <= S_WR_SETUP;
            cs_n  <= 1'b0;
            dq_oe <= 1'b1;
          end else begin
            state <= S_RD_SETUP;
          end
        end
        S_RD_SETUP: begin
          cs_n  <= 1'b0;
          oe_n  <= 1'b0;
          state <= S_RD_WAIT;
        end
        S_RD_WAIT: if (timer_zero) begin
          cs_n   <= 1'b1;
          oe_n   <= 1'b1;
          rvalid <= 1'b1;
          state  <= S_RD_DONE;
        end
        S_RD_DONE: begin
          rvalid <= 1'b0;
          state  <= S_TURNAROUND;
        end
        S_TURNAROUND: if (timer_zero) begin
          ready <= 1'b1;
          state <= S_IDLE;
        end
        S_WR_SETUP: begin
          we_n  <= 1'b0;
          state <= S_WR_STROBE;
        end
        S_WR_STROBE: if (timer_zero) begin
          we_n  <= 1'b1;
          cs_n  <= 1'b1;
          state <= S_WR_RELEASE;
        end
        S_WR_RELEASE: begin
          dq_oe <= 1'b0;
          ready <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              sample,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_dout  <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
      if (sample) rsp_rdata <= mem_din;
    end
  end
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPEED_GRADE   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_dq_oe
);
  localparam int ACC_CYC = ns_to_cyc(access_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int WP_CYC  = ns_to_cyc(strobe_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int TA_CYC  = ns_to_cyc(release_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int MAX_CYC = max3(ACC_CYC, WP_CYC, TA_CYC);
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic             accept, sample, tload, tzero;
  logic [CNT_W-1:0] tval;

  sram_ctl_seq #(
    .ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .timer_zero(tzero),
    .accept(accept), .sample(sample), .tload(tload), .tval(tval),
    .ready(req_ready), .rvalid(rsp_valid),
    .cs_n(mem_cs_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tload), .load_val(tval), .zero(tzero)
  );

  sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .sample(sample),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_din(mem_din),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPEED_GRADE   = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dout,
  input logic              mem_dq_oe
);
  localparam int ACC_CYC = ns_to_cyc(access_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int WP_CYC  = ns_to_cyc(strobe_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int TA_CYC  = ns_to_cyc(release_ns(SPEED_GRADE), CLK_PERIOD_NS);

  logic [7:0] we_cnt, rd_cnt, since_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_cnt   <= '0;
      rd_cnt   <= '0;
      since_oe <= 8'hFF;
    end else begin
      we_cnt   <= !mem_we_n ? we_cnt + 1'b1 : 8'd0;
      rd_cnt   <= (!mem_cs_n && !mem_oe_n) ? rd_cnt + 1'b1 : 8'd0;
      if (!mem_oe_n)              since_oe <= 8'd0;
      else if (since_oe != 8'hFF) since_oe <= since_oe + 1'b1;
    end
  end

  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n)); // R2
  AST_READ_ADDR_SETUP: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_cs_n) && !mem_oe_n) |-> $stable(mem_addr)); // R5
  AST_READ_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (32'(rd_cnt) == ACC_CYC)); // R3
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R4
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (32'(we_cnt) == WP_CYC)); // R6
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe)); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dout) && $stable(mem_addr))); // R7
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe); // R8
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    (32'(since_oe) <= TA_CYC) |-> !mem_dq_oe); // R8
endmodule

bind sram_async_ctl sram_async_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .SPEED_GRADE(SPEED_GRADE)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_async_ctl.sv
module tb_sram_async_ctl;
  localparam int PER    = 8;
  localparam int ACC_NS = 10;
  localparam int ACC_EXP = (ACC_NS + PER - 1) / PER;
  localparam int WP_EXP  = (8 + PER - 1) / PER;
  localparam int TA_EXP  = (5 + PER - 1) / PER;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, mem_din = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dout;
  logic [16:0] mem_addr;

  int tests = 0, fails = 0;

  always #(PER/2) clk = ~clk;

  sram_async_ctl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dout(mem_dout), .mem_din(mem_din), .mem_dq_oe(mem_dq_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // RAM model: stores at end of overlap, gives wrong data before access time
  logic [7:0] dev_mem [int];
  logic [7:0] ref_mem [int];
  time t_sel = 0;
  bit  wr_ovl = 0;
  int  we_run = 0, rd_run = 0, since_oe = 1000;
  bit  prev_rv = 0, prev_dq = 0, prev_cs = 1;
  logic [16:0] prev_addr = '0;

  always @(negedge mem_cs_n) t_sel = $time;

  function automatic logic [7:0] dev_rd(input int a);
    return dev_mem.exists(a) ? dev_mem[a] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!mem_cs_n && mem_we_n && !mem_oe_n)
      mem_din <= (($time - t_sel) >= ACC_NS) ? dev_rd(int'(mem_addr)) : ~dev_rd(int'(mem_addr));
    else
      mem_din <= 8'h5A;
    if (wr_ovl && (mem_cs_n || mem_we_n)) begin
      dev_mem[int'(mem_addr)] = mem_dout;
      check(mem_dq_oe == 1'b1, "R7 data driven at strobe end", int'(mem_dq_oe), 1);
    end
    wr_ovl = !mem_cs_n && !mem_we_n;
  end

  // Monitors
  always @(negedge clk) if (!rst) begin
    if (!mem_we_n) begin
      we_run++;
      if (we_run == 1) check(prev_dq == 1'b1, "R7 drive before strobe", int'(prev_dq), 1);
      if (mem_cs_n || !mem_oe_n) check(0, "R6 select/oe during strobe", {mem_cs_n, mem_oe_n}, 2'b01);
    end else if (we_run != 0) begin
      check(we_run == WP_EXP, "R6 strobe length", we_run, WP_EXP);
      we_run = 0;
    end
    if (!mem_cs_n && !mem_oe_n) begin
      if (rd_run == 0) check(prev_cs == 1'b1 && mem_addr == prev_addr, "R5 addr setup", int'(mem_addr), int'(prev_addr));
      rd_run++;
      since_oe = 0;
      check(!mem_dq_oe && mem_we_n, "R8 no contention", int'(mem_dq_oe), 0);
    end else begin
      if (rd_run != 0) begin
        check(rd_run == ACC_EXP, "R3 read window", rd_run, ACC_EXP);
        rd_run = 0;
      end
      if (mem_oe_n) since_oe++;
    end
    if (mem_dq_oe && !prev_dq)
      check(since_oe > TA_EXP, "R8 turnaround gap", since_oe, TA_EXP + 1);
    if (rsp_valid && prev_rv) check(0, "R4 response pulse width", 2, 1);
    if (req_ready && !(mem_cs_n && mem_we_n && mem_oe_n))
      check(0, "R2 idle deselect", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    prev_rv = rsp_valid; prev_dq = mem_dq_oe; prev_cs = mem_cs_n; prev_addr = mem_addr;
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    check(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
    req_valid = 1'b0;
    if (wr) ref_mem[int'(a)] = d;
  endtask

  task automatic do_read(input logic [16:0] a);
    int n = 0;
    logic [7:0] exp;
    exp = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    issue(1'b0, a, 8'h00);
    while (!rsp_valid && n < 64) begin @(negedge clk); n++; end
    check(rsp_valid == 1'b1, "R4 response seen", int'(rsp_valid), 1);
    check(rsp_rdata == exp, "R9 read-back data", int'(rsp_rdata), int'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid} == 6'b111010,
          "R1 reset outputs", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111010);
    rst = 1'b0;
    @(negedge clk);
    check({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid} == 6'b111010,
          "R1 after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111010);
    // Directed corners: top and bottom address, read->write turnaround
    issue(1'b1, 17'h1FFFF, 8'hC3);
    issue(1'b1, 17'h00000, 8'h3C);
    do_read(17'h1FFFF);
    issue(1'b1, 17'h00005, 8'hA7);
    do_read(17'h00000);
    do_read(17'h00005);
    issue(1'b1, 17'h1FFFF, 8'h18);
    do_read(17'h1FFFF);
    // Random mix
    for (int i = 0; i < 300; i++) begin
      int unsigned r = $urandom;
      logic [16:0] a = {11'h0, r[5:0]};
      if (r[7:6] == 2'b11) a = r[8] ? 17'h1FFFF : 17'h00000;
      if (r[31] || !ref_mem.exists(int'(a))) issue(1'b1, a, r[23:16]);
      else do_read(a);
    end
    repeat (10) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule